// File: doc/BRIEF.md
# Store Buffer with Fences

A per-core store buffer placed between an in-order load/store issue port and a single data cache. Every store is queued in the buffer first and is written to the cache in the background, oldest first, over a valid/ready write channel; only at that point does it become visible to other agents. A load from the same core searches the buffer. The youngest pending store to the same word is used as the load's source when its byte mask covers every byte the load asks for. When no pending store matches, the load reads the cache. When the youngest match covers only some of the bytes, the load waits until that store has drained.

The issue port also accepts two fence kinds, each in a single cycle. A full fence holds back every later load and every later store until all stores older than the fence have drained. A store fence holds back only later stores: loads keep going to the cache or take forwarded data. A fence is recorded as a marker holding the number of stores ahead of it, and it is released once that many stores have left the buffer. With no fence in effect, a load may complete ahead of older stores to other addresses.

Top module: `store_buffer_fenced`

## Requirements
- R1: After reset the buffer is empty and no fence is pending: `cwr_valid` and `rsp_valid` are low, and `req_ready` is high for a store, for either fence, and for a load while `crd_ready` is high.
- R2: The request code on `req_op` is 2'b00 load, 2'b01 store, 2'b10 full fence, 2'b11 store fence. A store is accepted only when fewer than DEPTH (8) stores are pending and no fence holds stores; with 8 pending, `req_ready` is low for a store.
- R3: Stores leave through the cache write channel in the order they were accepted. The head is removed only in a cycle with `cwr_valid` and `cwr_ready` both high, and `cwr_addr`, `cwr_data`, `cwr_mask` hold still while `cwr_ready` is low.
- R4: A load whose word address (address bits above bit 1) matches a pending store, where that store's byte mask covers every bit set in the load's `req_mask` (bit b selects data bits 8b+7..8b), is accepted without a cache read (`crd_valid` low). In the next cycle `rsp_valid` is high, `rsp_fwd` is high and `rsp_data` is the store's data with unrequested bytes zeroed.
- R5: When several pending stores match a load, only the youngest one is considered, both for the data and for the coverage test.
- R6: When the youngest match does not cover all requested bytes, the load is refused (`req_ready` low) until that store has drained; it then reads the cache.
- R7: A load with no matching pending store raises `crd_valid` with `crd_addr` equal to the load address and is accepted in the cycle `crd_ready` is high. In the next cycle `rsp_fwd` is low and `rsp_data` is `crd_data` with unrequested bytes zeroed.
- R8: A full fence is accepted in one cycle. Afterwards, no load or store is accepted until every store older than the fence has drained.
- R9: A store fence is accepted in one cycle. Afterwards, no store is accepted until every older store has drained, while loads are still accepted (from the cache or by forwarding).
- R10: A fence issued while the buffer is empty holds nothing back: the next load or store is accepted at once.
- R11: With no fence in effect, a load to an address with no pending store completes while older stores are still waiting in the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Issue-port request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_op | input | 2 | Request code: load, store, full fence, store fence |
| req_addr | input | 32 | Byte address of the load or store |
| req_wdata | input | 32 | Store data |
| req_mask | input | 4 | Store byte mask, or bytes a load needs |
| rsp_valid | output | 1 | Load result valid (cycle after acceptance) |
| rsp_data | output | 32 | Load result, unrequested bytes zero |
| rsp_fwd | output | 1 | Load result came from the buffer |
| crd_valid | output | 1 | Cache read request |
| crd_ready | input | 1 | Cache read granted, data valid this cycle |
| crd_addr | output | 32 | Cache read address |
| crd_data | input | 32 | Cache read data, same cycle as grant |
| cwr_valid | output | 1 | Head store offered to the cache |
| cwr_ready | input | 1 | Cache takes the head store |
| cwr_addr | output | 32 | Head store address |
| cwr_data | output | 32 | Head store data |
| cwr_mask | output | 4 | Head store byte mask |

## Verification
The embedded assertions take for granted that the issue port keeps `req_op` and the payload steady for the whole cycle in which it is sampled, and that the cache answers a read with `crd_data` in the same cycle as `crd_ready`. They also rely on the head of the buffer staying put while `cwr_ready` is low, which holds only if nothing but the write handshake removes entries. The stimulus changes every input shortly after a rising edge, reads outputs at the falling edge, and drives `crd_data` as a pure function of `crd_addr`, so the load data it expects can be computed from the address alone.

// File: rtl/sb_pkg.sv
// Shared definitions for the fenced store buffer.
// Assumes: request codes are driven on a 2-bit field by the issue port.
package sb_pkg;

    // Issue-port request codes (the code values are part of the port contract).
    typedef enum logic [1:0] {
        OP_LOAD      = 2'b00,
        OP_STORE     = 2'b01,
        OP_FENCE_ALL = 2'b10,
        OP_FENCE_ST  = 2'b11
    } op_e;

endpackage

// File: rtl/sb_fifo.sv
// Circular queue of pending stores. Exposes the head for draining and the
// whole contents in age order (index 0 = oldest) for the load search.
// Assumes: DEPTH is a power of two and at least 2; the caller never pushes
// when full nor pops when empty.
module sb_fifo #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int MW    = DW / 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [AW-1:0]              push_addr,
    input  logic [DW-1:0]              push_data,
    input  logic [MW-1:0]              push_mask,
    input  logic                       pop,
    output logic [CW-1:0]              count,
    output logic [AW-1:0]              head_addr,
    output logic [DW-1:0]              head_data,
    output logic [MW-1:0]              head_mask,
    output logic [DEPTH-1:0]           age_live,
    output logic [DEPTH-1:0][AW-1:0]   age_addr,
    output logic [DEPTH-1:0][DW-1:0]   age_data,
    output logic [DEPTH-1:0][MW-1:0]   age_mask
);

    logic [AW-1:0] mem_addr [DEPTH];
    logic [DW-1:0] mem_data [DEPTH];
    logic [MW-1:0] mem_mask [DEPTH];
    logic [IW-1:0] head;
    logic [IW-1:0] tail;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= tail + IW'(1);
            if (pop)  head <= head + IW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Storage write; contents need no reset since occupancy guards them.
    always_ff @(posedge clk) begin
        if (push) begin
            mem_addr[tail] <= push_addr;
            mem_data[tail] <= push_data;
            mem_mask[tail] <= push_mask;
        end
    end

    assign head_addr = mem_addr[head];
    assign head_data = mem_data[head];
    assign head_mask = mem_mask[head];

    // Rotate the ring into age order for the search logic.
    for (genvar i = 0; i < DEPTH; i++) begin : g_age
        logic [IW-1:0] slot;
        assign slot        = head + IW'(i);
        assign age_live[i] = CW'(i) < count;
        assign age_addr[i] = mem_addr[slot];
        assign age_data[i] = mem_data[slot];
        assign age_mask[i] = mem_mask[slot];
    end

    // R2
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count < CW'(DEPTH)));

    // R3
    fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

endmodule

// File: rtl/sb_fwd_match.sv
// Load search: finds the youngest live entry with the same word address as
// the load, and tells whether its byte mask covers the requested bytes.
// Assumes: entries arrive in age order, index 0 oldest.
module sb_fwd_match #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int MW    = 4,
    localparam int IW   = $clog2(DEPTH),
    localparam int OW   = $clog2(MW)
) (
    input  logic [DEPTH-1:0]          age_live,
    input  logic [DEPTH-1:0][AW-1:0]  age_addr,
    input  logic [DEPTH-1:0][MW-1:0]  age_mask,
    input  logic [AW-1:0]             ld_addr,
    input  logic [MW-1:0]             ld_need,
    output logic                      hit,
    output logic [IW-1:0]             hit_idx,
    output logic                      covers
);

    localparam logic [AW-1:0] WORD_MASK = ~AW'((1 << OW) - 1);

    // Scan oldest to youngest so the last match, the youngest, wins.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (age_live[i] && (((age_addr[i] ^ ld_addr) & WORD_MASK) == '0)) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    // Coverage is judged on the selected entry only.
    always_comb begin
        covers = hit && ((age_mask[hit_idx] & ld_need) == ld_need);
    end

endmodule

// File: rtl/sb_fence_track.sv
// Fence bookkeeping: a fence records a drain target equal to the running
// drain count plus the stores ahead of it; loads and/or stores are held
// until the running count reaches that target.
// Assumes: no store is accepted while any fence is pending, so a newer fence
// always covers everything an older one waits for.
module sb_fence_track #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int TW   = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fence_take,
    input  logic          fence_full,
    input  logic [CW-1:0] older_cnt,
    input  logic          drained,
    output logic          hold_loads,
    output logic          hold_stores
);

    logic [TW-1:0] drain_cnt;
    logic [TW-1:0] target;
    logic          pend_full;
    logic          pend_st;
    logic          waiting;
    logic          full_now;
    logic          st_now;

    // A recorded fence stays in force only until the target is reached.
    always_comb begin
        waiting     = drain_cnt != target;
        full_now    = pend_full && waiting;
        st_now      = pend_st && waiting;
        hold_loads  = full_now;
        hold_stores = full_now || st_now;
    end

    // Running drain count, and marker capture when a fence has work ahead.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drain_cnt <= '0;
            target    <= '0;
            pend_full <= 1'b0;
            pend_st   <= 1'b0;
        end else begin
            drain_cnt <= drain_cnt + TW'(drained);
            if (fence_take && older_cnt != '0) begin
                target    <= drain_cnt + TW'(older_cnt);
                pend_full <= full_now || fence_full;
                pend_st   <= st_now || !fence_full;
            end else begin
                pend_full <= full_now;
                pend_st   <= st_now;
            end
        end
    end

    // R8
    fence_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_full || pend_st) |-> ((target - drain_cnt) <= TW'(DEPTH)));

endmodule

// File: rtl/store_buffer_fenced.sv
// Store buffer with full and store-only fences between an in-order issue
// port and a data cache. Stores queue and drain oldest-first over a
// valid/ready write channel; loads forward from the youngest matching store
// or read the cache; fences stall only the traffic they order.
// Assumes: cache read data is valid in the same cycle as crd_ready; request
// fields are steady while req_valid is high.
module store_buffer_fenced
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int MW   = DW / 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [MW-1:0] req_mask,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_fwd,
    output logic          crd_valid,
    input  logic          crd_ready,
    output logic [AW-1:0] crd_addr,
    input  logic [DW-1:0] crd_data,
    output logic          cwr_valid,
    input  logic          cwr_ready,
    output logic [AW-1:0] cwr_addr,
    output logic [DW-1:0] cwr_data,
    output logic [MW-1:0] cwr_mask
);

    op_e                      op;
    logic                     is_ld, is_st, is_fence;
    logic                     push, pop, fence_take;
    logic [CW-1:0]            count;
    logic [DEPTH-1:0]         age_live;
    logic [DEPTH-1:0][AW-1:0] age_addr;
    logic [DEPTH-1:0][DW-1:0] age_data;
    logic [DEPTH-1:0][MW-1:0] age_mask;
    logic                     hit, covers;
    logic [IW-1:0]            hit_idx;
    logic                     hold_loads, hold_stores;
    logic                     store_ok, ld_fwd_ok, ld_cache;
    logic [DW-1:0]            byte_bits;

    assign op       = op_e'(req_op);
    assign is_ld    = op == OP_LOAD;
    assign is_st    = op == OP_STORE;
    assign is_fence = op == OP_FENCE_ALL || op == OP_FENCE_ST;

    sb_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .MW(MW)) i_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (req_addr),
        .push_data (req_wdata),
        .push_mask (req_mask),
        .pop       (pop),
        .count     (count),
        .head_addr (cwr_addr),
        .head_data (cwr_data),
        .head_mask (cwr_mask),
        .age_live  (age_live),
        .age_addr  (age_addr),
        .age_data  (age_data),
        .age_mask  (age_mask)
    );

    sb_fwd_match #(.DEPTH(DEPTH), .AW(AW), .MW(MW)) i_match (
        .age_live (age_live),
        .age_addr (age_addr),
        .age_mask (age_mask),
        .ld_addr  (req_addr),
        .ld_need  (req_mask),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .covers   (covers)
    );

    sb_fence_track #(.DEPTH(DEPTH)) i_fence (
        .clk         (clk),
        .rst_n       (rst_n),
        .fence_take  (fence_take),
        .fence_full  (op == OP_FENCE_ALL),
        .older_cnt   (count),
        .drained     (pop),
        .hold_loads  (hold_loads),
        .hold_stores (hold_stores)
    );

    // Byte-enable expansion of the load's requested-byte mask.
    for (genvar b = 0; b < MW; b++) begin : g_bytes
        assign byte_bits[8*b +: 8] = {8{req_mask[b]}};
    end

    // Per-request acceptance conditions.
    always_comb begin
        store_ok  = (count != CW'(DEPTH)) && !hold_stores;
        ld_fwd_ok = !hold_loads && covers;
        ld_cache  = !hold_loads && !hit;
        case (op)
            OP_LOAD:  req_ready = ld_fwd_ok || (ld_cache && crd_ready);
            OP_STORE: req_ready = store_ok;
            default:  req_ready = 1'b1;
        endcase
    end

    // Handshakes on the issue port and both cache channels.
    always_comb begin
        crd_valid  = req_valid && is_ld && ld_cache;
        crd_addr   = req_addr;
        push       = req_valid && req_ready && is_st;
        fence_take = req_valid && is_fence;
        cwr_valid  = count != '0;
        pop        = cwr_valid && cwr_ready;
    end

    // Registered load response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_fwd   <= 1'b0;
        end else begin
            rsp_valid <= req_valid && req_ready && is_ld;
            rsp_fwd   <= ld_fwd_ok;
            rsp_data  <= (ld_fwd_ok ? age_data[hit_idx] : crd_data) & byte_bits;
        end
    end

    // R3
    cwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cwr_valid && !cwr_ready) |=> (cwr_valid && $stable(cwr_addr)
                                       && $stable(cwr_data) && $stable(cwr_mask)));

    // R4
    fwd_no_cache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_ld && hit) |-> !crd_valid);

    // R8
    full_fence_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_loads |-> !(req_valid && req_ready && (is_ld || is_st)));

    // R9
    store_fence_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_stores |-> !push);

endmodule

// File: tb/test_store_buffer_fenced.sv
module test_store_buffer_fenced;
    import sb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_mask = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_fwd;
    logic        crd_valid;
    logic        crd_ready = 1'b1;
    logic [31:0] crd_addr;
    logic [31:0] crd_data;
    logic        cwr_valid;
    logic        cwr_ready = 1'b0;
    logic [31:0] cwr_addr;
    logic [31:0] cwr_data;
    logic [3:0]  cwr_mask;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic        got_rdy, got_crd, got_rv, got_fwd;
    logic [31:0] got_rd;
    logic [31:0] plog [64];
    int          pn = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] cache_val(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    function automatic logic [31:0] bm(input logic [3:0] m);
        return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
    endfunction

    assign crd_data = cache_val(crd_addr);

    store_buffer_fenced i_store_buffer_fenced (.*);

    // Log every store the cache takes, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && cwr_valid && cwr_ready) begin
            plog[pn % 64] = cwr_data;
            pn++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request for one cycle; captures acceptance, cache read and response.
    task automatic req(input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] d, input logic [3:0] m);
        @(posedge clk); #2;
        req_op = op; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
        @(negedge clk);
        got_rdy = req_ready;
        got_crd = crd_valid;
        @(posedge clk); #2;
        req_valid = 1'b0;
        @(negedge clk);
        got_rv = rsp_valid; got_rd = rsp_data; got_fwd = rsp_fwd;
    endtask

    task automatic drain();
        @(posedge clk); #2; cwr_ready = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!cwr_valid) break;
        end
        @(posedge clk); #2; cwr_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            done = 1;
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 cwr_valid", 32'(cwr_valid), 0);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 load ready", 32'(req_ready), 1);
        req_op = OP_STORE; #1;
        chk("R1 store ready", 32'(req_ready), 1);
        req_op = OP_FENCE_ALL; #1;
        chk("R1 fence ready", 32'(req_ready), 1);

        // R7 load with no pending store reads the cache
        req(OP_LOAD, 32'h100, 0, 4'hF);
        chk("R7 ready", 32'(got_rdy), 1);
        chk("R7 crd_valid", 32'(got_crd), 1);
        chk("R7 rsp_valid", 32'(got_rv), 1);
        chk("R7 rsp_fwd", 32'(got_fwd), 0);
        chk("R7 data", got_rd, cache_val(32'h100));
        req(OP_LOAD, 32'h104, 0, 4'h6);
        chk("R7 partial bytes", got_rd, cache_val(32'h104) & bm(4'h6));

        // R4 forwarding, no cache read
        pn = 0;
        req(OP_STORE, 32'h200, 32'hDEADBEEF, 4'hF);
        chk("R2 store accepted", 32'(got_rdy), 1);
        req(OP_LOAD, 32'h202, 0, 4'h3);
        chk("R4 ready", 32'(got_rdy), 1);
        chk("R4 no cache read", 32'(got_crd), 0);
        chk("R4 rsp_fwd", 32'(got_fwd), 1);
        chk("R4 data", got_rd, 32'h0000BEEF);

        // R5 youngest match wins
        req(OP_STORE, 32'h200, 32'h11111111, 4'hF);
        req(OP_STORE, 32'h200, 32'h22222222, 4'hF);
        req(OP_STORE, 32'h200, 32'h33333333, 4'hF);
        req(OP_LOAD, 32'h200, 0, 4'hF);
        chk("R5 youngest data", got_rd, 32'h33333333);

        // R11 load to another address completes while stores wait
        req(OP_LOAD, 32'h300, 0, 4'hF);
        chk("R11 ready", 32'(got_rdy), 1);
        chk("R11 data", got_rd, cache_val(32'h300));
        chk("R11 stores still pending", 32'(cwr_valid), 1);

        // R3 drain order
        drain();
        chk("R3 pop count", 32'(pn), 4);
        chk("R3 pop0", plog[0], 32'hDEADBEEF);
        chk("R3 pop1", plog[1], 32'h11111111);
        chk("R3 pop2", plog[2], 32'h22222222);
        chk("R3 pop3", plog[3], 32'h33333333);

        // R2 full buffer refuses stores, loads still served
        pn = 0;
        for (int i = 0; i < 8; i++) req(OP_STORE, 32'h400 + 32'(4 * i), 32'hA0000000 + 32'(i), 4'hF);
        req(OP_STORE, 32'h480, 32'hBAD0BAD0, 4'hF);
        chk("R2 full refuses store", 32'(got_rdy), 0);
        req(OP_LOAD, 32'h41C, 0, 4'hF);
        chk("R2 load while full", 32'(got_rdy), 1);
        chk("R4 fwd while full", got_rd, 32'hA0000007);
        drain();
        chk("R3 eight pops", 32'(pn), 8);
        for (int i = 0; i < 8; i++) chk("R3 fill order", plog[i], 32'hA0000000 + 32'(i));

        // R6 partial coverage stalls until drained
        req(OP_STORE, 32'h500, 32'h55667788, 4'h3);
        req(OP_LOAD, 32'h500, 0, 4'hF);
        chk("R6 partial refused", 32'(got_rdy), 0);
        req(OP_LOAD, 32'h500, 0, 4'h1);
        chk("R6 covered subset ready", 32'(got_rdy), 1);
        chk("R6 covered subset data", got_rd, 32'h00000088);
        req(OP_STORE, 32'h500, 32'h99AA0000, 4'hC);
        req(OP_LOAD, 32'h500, 0, 4'h3);
        chk("R5 youngest not covering refuses", 32'(got_rdy), 0);
        drain();
        req(OP_LOAD, 32'h500, 0, 4'hF);
        chk("R6 after drain ready", 32'(got_rdy), 1);
        chk("R6 after drain from cache", 32'(got_fwd), 0);

        // R8 full fence
        req(OP_STORE, 32'h600, 32'h6001, 4'hF);
        req(OP_STORE, 32'h604, 32'h6002, 4'hF);
        req(OP_FENCE_ALL, 0, 0, 0);
        chk("R8 fence one cycle", 32'(got_rdy), 1);
        req(OP_LOAD, 32'h700, 0, 4'hF);
        chk("R8 load held", 32'(got_rdy), 0);
        req(OP_STORE, 32'h608, 32'h6003, 4'hF);
        chk("R8 store held", 32'(got_rdy), 0);
        @(posedge clk); #2; cwr_ready = 1'b1;
        @(posedge clk); #2; cwr_ready = 1'b0;
        req(OP_LOAD, 32'h700, 0, 4'hF);
        chk("R8 held after partial drain", 32'(got_rdy), 0);
        drain();
        req(OP_LOAD, 32'h700, 0, 4'hF);
        chk("R8 load after drain", 32'(got_rdy), 1);
        req(OP_STORE, 32'h608, 32'h6003, 4'hF);
        chk("R8 store after drain", 32'(got_rdy), 1);
        drain();

        // R9 store fence
        req(OP_STORE, 32'h600, 32'h7001, 4'hF);
        req(OP_FENCE_ST, 0, 0, 0);
        chk("R9 fence one cycle", 32'(got_rdy), 1);
        req(OP_LOAD, 32'h700, 0, 4'hF);
        chk("R9 cache load proceeds", 32'(got_rdy), 1);
        req(OP_LOAD, 32'h600, 0, 4'hF);
        chk("R9 forward proceeds", 32'(got_rdy), 1);
        chk("R9 forward data", got_rd, 32'h7001);
        req(OP_STORE, 32'h604, 32'h7002, 4'hF);
        chk("R9 store held", 32'(got_rdy), 0);
        drain();
        req(OP_STORE, 32'h604, 32'h7002, 4'hF);
        chk("R9 store after drain", 32'(got_rdy), 1);
        drain();

        // R10 fence on empty buffer
        req(OP_FENCE_ALL, 0, 0, 0);
        req(OP_LOAD, 32'h700, 0, 4'hF);
        chk("R10 load not held", 32'(got_rdy), 1);
        req(OP_FENCE_ST, 0, 0, 0);
        req(OP_STORE, 32'h900, 32'h1, 4'hF);
        chk("R10 store not held", 32'(got_rdy), 1);
        drain();

        // R4/R6 sweep over store mask x load mask
        for (int m = 1; m < 16; m++) begin
            for (int n = 1; n < 16; n++) begin
                logic [31:0] d;
                d = {4{8'(m * 16 + n)}} ^ 32'h01234567;
                req(OP_STORE, 32'h800, d, 4'(m));
                req(OP_LOAD, 32'h800, 0, 4'(n));
                chk("R6 sweep ready", 32'(got_rdy), 32'(((m & n) == n) ? 1 : 0));
                if ((m & n) == n) chk("R4 sweep data", got_rd, d & bm(4'(n)));
                drain();
            end
        end

        if (!done) begin
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            done = 1;
            $finish;
        end
    end

endmodule